// File: doc/BRIEF.md
# Hardware Register Read Gate

This block answers a user-level "read hardware register" instruction. The core presents a 5-bit register index together with a request strobe and its current privilege state. The block decides whether the read is permitted, picks the matching value from a small set of machine-state sources and returns it one cycle later. A read that is not permitted, or that names an index with no source, returns no data and raises a reserved-instruction exception flag instead.

Permission is granted per register. A 32-bit enable mask holds one bit for each index. Privileged code is never gated. The mask is a register inside the block, loaded through a one-port write interface, and its current contents are driven out so the surrounding logic can observe them. The counter and the other sources are produced elsewhere and arrive as plain inputs.

Top module: `hwr_read_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rd_vld and rd_exc are 0, rd_data is all zeros and mask_q is all zeros.
- R2: For each cycle with req_vld high, exactly one of rd_vld or rd_exc is high in the following cycle. Neither is high in the cycle after a cycle with req_vld low.
- R3: A request for an index n from 0 to 5 is granted when priv_mode is 1 or bit n of mask_q is 1. Otherwise it raises rd_exc.
- R4: A request for an index from 6 to 31 always raises rd_exc, whatever the mask and privilege.
- R5: A granted index 0 returns bits 9:0 of base_reg in rd_data[9:0]. All other bits are zero.
- R6: A granted index 1, 3 or 4 returns sync_step, cnt_res or perf_reg respectively, zero-extended to XLEN.
- R7: A granted index 2 returns cycle_cnt sign-extended from bit 31 to XLEN.
- R8: A granted index 5 returns cfg_bit in rd_data[0]. All other bits are zero.
- R9: When msk_we is high at a clock edge, mask_q takes msk_wdata at that edge. A request in the same cycle is judged against the mask value from before the write.
- R10: rd_data is all zeros in every cycle where rd_vld is low, including cycles with rd_exc high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Read request strobe, one request per cycle |
| req_idx | input | 5 | Hardware register index |
| priv_mode | input | 1 | Core runs privileged; bypasses the mask |
| msk_we | input | 1 | Load the enable mask |
| msk_wdata | input | 32 | New enable mask value |
| base_reg | input | 32 | Base register; low 10 bits are the CPU number |
| sync_step | input | 32 | Cache synchronisation step size |
| cycle_cnt | input | 32 | Free-running cycle counter |
| cnt_res | input | 32 | Cycle counter resolution |
| perf_reg | input | 32 | Performance register |
| cfg_bit | input | 1 | Configuration bit |
| mask_q | output | 32 | Current enable mask |
| rd_data | output | XLEN | Read result, zero unless rd_vld |
| rd_vld | output | 1 | Read granted, rd_data valid |
| rd_exc | output | 1 | Reserved-instruction exception |

## Verification
The assertions assume that the source inputs are sampled only at the edge where a request is taken. They assume nothing about the sources holding their values across later cycles, so the bench changes cycle_cnt and the other sources freely between requests. They also assume req_idx is a known value whenever req_vld is high. The bench therefore drives a defined index on every cycle, including idle ones. It issues requests back-to-back and places mask writes in the same cycle as reads, so the old-mask rule is exercised under the same conditions the checker covers.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

  localparam int IDX_W   = 5;
  localparam int MASK_W  = 1 << IDX_W;
  localparam int SRC_W   = 32;
  localparam int NUM_SRC = 6;
  localparam int WIDE_W  = 64;
  localparam int CPU_W   = 10;

  typedef enum logic [IDX_W-1:0] {
    SEL_CPUNUM = 5'd0,
    SEL_STEP   = 5'd1,
    SEL_CYCLE  = 5'd2,
    SEL_RES    = 5'd3,
    SEL_PERF   = 5'd4,
    SEL_CFG    = 5'd5
  } hwr_sel_e;

  typedef struct packed {
    logic [SRC_W-1:0] base;
    logic [SRC_W-1:0] step;
    logic [SRC_W-1:0] cycle;
    logic [SRC_W-1:0] res;
    logic [SRC_W-1:0] perf;
    logic             cfg;
  } hwr_src_t;

  function automatic logic [WIDE_W-1:0] hwr_zext(input logic [SRC_W-1:0] v);
    return {{(WIDE_W-SRC_W){1'b0}}, v};
  endfunction

  function automatic logic [WIDE_W-1:0] hwr_sext(input logic [SRC_W-1:0] v);
    return {{(WIDE_W-SRC_W){v[SRC_W-1]}}, v};
  endfunction

  function automatic logic [WIDE_W-1:0] hwr_cpunum(input logic [SRC_W-1:0] v);
    return {{(WIDE_W-CPU_W){1'b0}}, v[CPU_W-1:0]};
  endfunction

endpackage

// File: rtl/hwr_mask_reg.sv
module hwr_mask_reg
  import hwr_pkg::*;
#(
  parameter int W = MASK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/hwr_perm_check.sv
module hwr_perm_check
  import hwr_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              priv,
  input  logic [MASK_W-1:0] mask,
  output logic              known,
  output logic              allow
);

  logic [N_SRC-1:0] hit;
  logic [N_SRC-1:0] grant;

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    assign hit[g]   = (idx == IDX_W'(g));
    assign grant[g] = hit[g] & (priv | mask[g]);
  end

  assign known = |hit;
  assign allow = |grant;

endmodule

// File: rtl/hwr_src_mux.sv
module hwr_src_mux
  import hwr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [IDX_W-1:0] idx,
  input  hwr_src_t         src,
  output logic [XLEN-1:0]  value
);

  logic [WIDE_W-1:0] wide;

  always_comb begin
    unique case (idx)
      SEL_CPUNUM: wide = hwr_cpunum(src.base);
      SEL_STEP:   wide = hwr_zext(src.step);
      SEL_CYCLE:  wide = hwr_sext(src.cycle);
      SEL_RES:    wide = hwr_zext(src.res);
      SEL_PERF:   wide = hwr_zext(src.perf);
      SEL_CFG:    wide = {{(WIDE_W-1){1'b0}}, src.cfg};
      default:    wide = '0;
    endcase
  end

  assign value = wide[XLEN-1:0];

endmodule

// File: rtl/hwr_read_gate.sv
module hwr_read_gate
  import hwr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_vld,
  input  logic [IDX_W-1:0]      req_idx,
  input  logic                  priv_mode,
  input  logic                  msk_we,
  input  logic [MASK_W-1:0]     msk_wdata,
  input  logic [SRC_W-1:0]      base_reg,
  input  logic [SRC_W-1:0]      sync_step,
  input  logic [SRC_W-1:0]      cycle_cnt,
  input  logic [SRC_W-1:0]      cnt_res,
  input  logic [SRC_W-1:0]      perf_reg,
  input  logic                  cfg_bit,
  output logic [MASK_W-1:0]     mask_q,
  output logic [XLEN-1:0]       rd_data,
  output logic                  rd_vld,
  output logic                  rd_exc
);

  logic            idx_known;
  logic            idx_allow;
  logic            take_ok;
  logic            take_bad;
  logic [XLEN-1:0] sel_value;
  hwr_src_t        src;

  assign src = '{base: base_reg, step: sync_step, cycle: cycle_cnt,
                 res: cnt_res, perf: perf_reg, cfg: cfg_bit};

  hwr_mask_reg #(.W(MASK_W)) mask_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (msk_we),
    .wdata (msk_wdata),
    .q     (mask_q)
  );

  hwr_perm_check #(.N_SRC(NUM_SRC)) perm_i (
    .idx   (req_idx),
    .priv  (priv_mode),
    .mask  (mask_q),
    .known (idx_known),
    .allow (idx_allow)
  );

  hwr_src_mux #(.XLEN(XLEN)) mux_i (
    .idx   (req_idx),
    .src   (src),
    .value (sel_value)
  );

  assign take_ok  = req_vld & idx_allow;
  assign take_bad = req_vld & ~idx_allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_exc  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld  <= take_ok;
      rd_exc  <= take_bad;
      rd_data <= take_ok ? sel_value : '0;
    end
  end

endmodule

// File: rtl/hwr_read_gate_chk.sv
module hwr_read_gate_chk
  import hwr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [IDX_W-1:0]  req_idx,
  input logic              priv_mode,
  input logic              msk_we,
  input logic [MASK_W-1:0] msk_wdata,
  input logic [MASK_W-1:0] mask_q,
  input logic              idx_known,
  input logic [XLEN-1:0]   rd_data,
  input logic              rd_vld,
  input logic              rd_exc
);

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (rd_vld ^ rd_exc));

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rd_vld && !rd_exc));

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !idx_known) |=> rd_exc);

  // R3
  user_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !priv_mode && !mask_q[req_idx]) |=> rd_exc);

  // R3
  priv_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && priv_mode && idx_known) |=> rd_vld);

  // R8
  cfg_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && priv_mode && req_idx == 5'd5) |=> (rd_data[XLEN-1:1] == '0));

  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msk_we |=> (mask_q == $past(msk_wdata)));

  // R10
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |-> (rd_data == '0));

endmodule

bind hwr_read_gate hwr_read_gate_chk #(.XLEN(XLEN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_idx   (req_idx),
  .priv_mode (priv_mode),
  .msk_we    (msk_we),
  .msk_wdata (msk_wdata),
  .mask_q    (mask_q),
  .idx_known (idx_known),
  .rd_data   (rd_data),
  .rd_vld    (rd_vld),
  .rd_exc    (rd_exc)
);

// File: tb/hwr_read_gate_tb_top.sv
module hwr_read_gate_tb_top;

  localparam int XLEN = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_vld = 1'b0;
  logic [4:0]       req_idx = '0;
  logic             priv_mode = 1'b0;
  logic             msk_we = 1'b0;
  logic [31:0]      msk_wdata = '0;
  logic [31:0]      base_reg = '0;
  logic [31:0]      sync_step = '0;
  logic [31:0]      cycle_cnt = '0;
  logic [31:0]      cnt_res = '0;
  logic [31:0]      perf_reg = '0;
  logic             cfg_bit = 1'b0;
  logic [31:0]      mask_q;
  logic [XLEN-1:0]  rd_data;
  logic             rd_vld;
  logic             rd_exc;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model_mask = '0;

  always #10 clk = ~clk;

  hwr_read_gate #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_idx(req_idx),
    .priv_mode(priv_mode), .msk_we(msk_we), .msk_wdata(msk_wdata),
    .base_reg(base_reg), .sync_step(sync_step), .cycle_cnt(cycle_cnt),
    .cnt_res(cnt_res), .perf_reg(perf_reg), .cfg_bit(cfg_bit),
    .mask_q(mask_q), .rd_data(rd_data), .rd_vld(rd_vld), .rd_exc(rd_exc)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock of stimulus with a behavioural prediction of the next outputs.
  task automatic cyc(input logic rv, input int idx, input logic pm,
                     input logic we, input logic [31:0] wd);
    logic [63:0] e_data;
    logic        e_vld, e_exc, ok;
    string       tag;
    req_vld = rv; req_idx = idx[4:0]; priv_mode = pm;
    msk_we = we; msk_wdata = wd;
    e_data = 64'd0;
    ok = (idx <= 5) && (pm || model_mask[idx]);
    e_vld = rv && ok;
    e_exc = rv && !ok;
    if (!rv)            tag = "R2";
    else if (idx > 5)   tag = "R4";
    else if (!ok)       tag = "R3";
    else if (idx == 0)  tag = "R5";
    else if (idx == 2)  tag = "R7";
    else if (idx == 5)  tag = "R8";
    else                tag = "R6";
    if (e_vld) begin
      case (idx)
        0: e_data = 64'(base_reg % 1024);
        1: e_data = 64'(sync_step);
        2: e_data = 64'($signed(cycle_cnt));
        3: e_data = 64'(cnt_res);
        4: e_data = 64'(perf_reg);
        default: e_data = cfg_bit ? 64'd1 : 64'd0;
      endcase
    end
    if (we) model_mask = wd;
    @(posedge clk);
    @(negedge clk);
    check(tag, {63'd0, rd_vld}, {63'd0, e_vld});
    check(tag, {63'd0, rd_exc}, {63'd0, e_exc});
    check(e_vld ? tag : "R10", rd_data, e_data);
    check("R9", {32'd0, mask_q}, {32'd0, model_mask});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", {63'd0, rd_vld}, 64'd0);
    check("R1", {63'd0, rd_exc}, 64'd0);
    check("R1", rd_data, 64'd0);
    check("R1", {32'd0, mask_q}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {32'd0, mask_q}, 64'd0);
    check("R1", {62'd0, rd_vld, rd_exc}, 64'd0);

    base_reg = 32'h1234_5A7B; sync_step = 32'h40; cycle_cnt = 32'h8000_0011;
    cnt_res = 32'd2; perf_reg = 32'hDEAD_BEEF; cfg_bit = 1'b1;

    cyc(0, 0, 0, 0, 0);
    cyc(0, 3, 1, 0, 0);
    // user mode, empty mask: all denied (R3, R4)
    for (int i = 0; i < 8; i++) cyc(1, i, 0, 0, 0);
    // privileged: every index (R5..R8, R4)
    for (int i = 0; i < 32; i++) cyc(1, i, 1, 0, 0);
    // write in same cycle as read: old mask applies (R9)
    cyc(1, 0, 0, 1, 32'h0000_0015);
    for (int i = 0; i < 8; i++) cyc(1, i, 0, 0, 0);
    // full mask: only 0..5 granted (R4)
    cyc(0, 0, 0, 1, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) cyc(1, i, 0, 0, 0);
    // positive counter, cleared config bit, CPU number all ones (R7, R8, R5)
    cycle_cnt = 32'h7FFF_FFFF; cfg_bit = 1'b0; base_reg = 32'hFFFF_FFFF;
    cyc(1, 2, 0, 0, 0);
    cyc(1, 5, 1, 0, 0);
    cyc(1, 0, 0, 0, 0);
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      base_reg  = $urandom; sync_step = $urandom; cycle_cnt = $urandom;
      cnt_res   = $urandom; perf_reg  = $urandom; cfg_bit = 1'($urandom);
      cyc(1'($urandom_range(0, 3) != 0), $urandom_range(0, 9),
          1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 7) == 0),
          $urandom);
    end
    cyc(0, 0, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule